// File: doc/BRIEF.md
# Zero-Overhead Opcode Dispatch Unit

This unit sits beside the micro-sequencer of a microcoded processor and turns the stream of macro-instruction opcode bytes into microcode entry addresses. It keeps a small byte buffer of prefetched opcodes and a pointer into it. When the last microinstruction of an opcode body raises the dispatch strobe, the unit supplies the next micro-address in that same cycle. That address is the entry point of the next opcode, formed from a base register and the opcode byte. If the buffer has run dry, the address is a fixed refill routine instead. Because the jump is folded into the final microinstruction, a dispatch adds no cycle.

The refill routine starts a burst read of four 16-bit words into the buffer. When the last word arrives, the pointer returns to zero and the routine simply dispatches again. A dispatch raised while the burst is still outstanding is held off with a stall until the buffer is full.

Top module: `opdisp_unit`

## Requirements
- R1: After reset the pointer is in the overflowed state, so the first dispatch yields the refill entry address (default 12'h010), and `mem_rd_req`, `stall` and `nxt_vld` are low while no dispatch is requested.
- R2: A dispatch with a byte available drives `nxt_vld` high and `nxt_uaddr` = {base register (4 bits), buffer byte at the pointer (8 bits)} combinationally, in the same cycle as `disp_req`.
- R3: Each accepted dispatch advances the pointer by one, so back-to-back dispatches in consecutive cycles return buffer bytes 0 to 7 in order.
- R4: Once all eight bytes are consumed, every dispatch yields the refill entry address, and the pointer does not move however often dispatch is repeated.
- R5: `refill_start` while no refill is pending produces a single-cycle `mem_rd_req` in the next cycle; a `refill_start` while a refill is pending has no effect.
- R6: The four returned words fill the buffer in arrival order: word k places bits [7:0] at byte 2k and bits [15:8] at byte 2k+1.
- R7: A dispatch while a refill is pending raises `stall` and holds `nxt_vld` low, with the pointer unchanged; in the cycle after the fourth word arrives, the pointer is zero and a held dispatch returns byte 0.
- R8: `base_ld` loads `base_in` at the clock edge; a dispatch in the same cycle still uses the old base, and later dispatches use the new one.
- R9: `mem_rd_vld` while no refill is pending leaves the buffer contents unchanged.
- R10: Without `disp_req` the pointer holds, so no byte is consumed in idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_ld | input | 1 | Load strobe for the entry base register |
| base_in | input | 4 | New entry base value |
| disp_req | input | 1 | Dispatch strobe from the last microinstruction of an opcode body |
| refill_start | input | 1 | Start strobe from the refill routine |
| mem_rd_vld | input | 1 | A returned memory word is valid |
| mem_rd_data | input | 16 | Returned memory word |
| nxt_vld | output | 1 | Dispatch resolved this cycle |
| nxt_uaddr | output | 12 | Next micro-address: opcode entry or refill entry |
| stall | output | 1 | Dispatch held while a refill is pending |
| mem_rd_req | output | 1 | One-cycle request for a four-word burst read |

## Verification
On every cycle the assertions check the pointer rules: it steps by exactly one on an accepted dispatch, the overflow bit stays set until a refill completes, the pointer is frozen while a refill is pending and reads zero after the final word. They also check that the read request is a single-cycle pulse that follows a start. Only the bench's scenarios can show that the right byte reaches the address output. That covers the byte order of the fill, the base register timing, a stray return word leaving the buffer alone, and the stalled dispatch resuming on byte 0. The bench mixes random sequences with directed cases for each of these.

// File: rtl/opdisp_pkg.sv
// Package: shared widths and the byte type for the opcode dispatch unit.
// Assumes opcodes are always 8 bits wide.
package opdisp_pkg;
    localparam int OP_W = 8;
    typedef logic [OP_W-1:0] opbyte_t;
endpackage

// File: rtl/opdisp_ptr.sv
// Byte pointer: low bits index the opcode buffer, top bit flags exhaustion.
// Assumes inc is never raised while the overflow bit is set.
module opdisp_ptr #(
    parameter int BUF_BYTES = 8,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_q;

    // Pointer register: resets overflowed, clears on refill, steps on dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= {1'b1, {IDX_W{1'b0}}};
        else if (clr)
            ptr_q <= '0;
        else if (inc)
            ptr_q <= ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    // R3: an accepted dispatch advances the pointer by exactly one.
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R4: exhaustion persists until a refill clears it.
    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q[IDX_W] && !clr) |=> ptr_q[IDX_W]);

    // R4: no dispatch may consume a byte once exhausted.
    p_no_inc_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !ptr_q[IDX_W]);
endmodule

// File: rtl/opdisp_buf.sv
// Opcode byte buffer, written a memory word at a time, read one byte at a time.
// Assumes WORD_W is a multiple of 8 and divides the buffer size evenly.
module opdisp_buf
    import opdisp_pkg::*;
#(
    parameter int BUF_BYTES = 8,
    parameter int WORD_W    = 16,
    localparam int IDX_W  = $clog2(BUF_BYTES),
    localparam int BPW    = WORD_W / OP_W,
    localparam int WORDS  = BUF_BYTES / BPW,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output opbyte_t           rd_byte
);
    opbyte_t mem_q [BUF_BYTES];

    for (genvar b = 0; b < BUF_BYTES; b++) begin : g_byte
        // Byte slot b takes its lane of the word whose index covers it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[b] <= '0;
            else if (wr_en && (wr_idx == WIDX_W'(b / BPW)))
                mem_q[b] <= wr_data[(b % BPW)*OP_W +: OP_W];
        end
    end

    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/opdisp_refill.sv
// Refill sequencer: issues one burst request and counts the returned words.
// Assumes the memory returns exactly WORDS words per request, in order.
module opdisp_refill #(
    parameter int WORDS = 4,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_vld,
    output logic              rd_req,
    output logic              busy,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_idx,
    output logic              done
);
    logic              busy_q;
    logic              req_q;
    logic [WIDX_W-1:0] cnt_q;
    logic              last;

    assign last   = (cnt_q == WIDX_W'(WORDS - 1));
    assign wr_en  = busy_q && rd_vld;
    assign wr_idx = cnt_q;
    assign done   = wr_en && last;

    // Busy flag and word counter across one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (wr_en) begin
            cnt_q  <= cnt_q + 1'b1;
            if (last)
                busy_q <= 1'b0;
        end
    end

    // One-cycle request pulse following an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= !busy_q && start;
    end

    assign rd_req = req_q;
    assign busy   = busy_q;

    // R5: the request lasts a single cycle.
    p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

    // R5: a start while idle produces a request next cycle.
    p_req_follows_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> (req_q && busy_q));

    // R5: a start while pending raises no second request.
    p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy_q) |=> !req_q);
endmodule

// File: rtl/opdisp_unit.sv
// Opcode dispatch unit top: resolves the next micro-address in the cycle of
// the dispatch strobe, from the buffer byte or the refill entry.
// Assumes the microcode raises refill_start from the refill routine and
// re-dispatches afterwards; a dispatch during a pending refill is stalled.
module opdisp_unit
    import opdisp_pkg::*;
#(
    parameter int                    UADDR_W      = 12,
    parameter int                    BUF_BYTES    = 8,
    parameter int                    WORD_W       = 16,
    parameter logic [UADDR_W-1:0]    REFILL_UADDR = 12'h010,
    localparam int BASE_W = UADDR_W - OP_W,
    localparam int IDX_W  = $clog2(BUF_BYTES),
    localparam int PTR_W  = IDX_W + 1,
    localparam int BPW    = WORD_W / OP_W,
    localparam int WORDS  = BUF_BYTES / BPW,
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_ld,
    input  logic [BASE_W-1:0]  base_in,
    input  logic               disp_req,
    input  logic               refill_start,
    input  logic               mem_rd_vld,
    input  logic [WORD_W-1:0]  mem_rd_data,
    output logic               nxt_vld,
    output logic [UADDR_W-1:0] nxt_uaddr,
    output logic               stall,
    output logic               mem_rd_req
);
    logic [BASE_W-1:0] base_q;
    logic [PTR_W-1:0]  ptr;
    logic              ovf;
    logic              ptr_inc;
    logic              busy;
    logic              fill_en;
    logic [WIDX_W-1:0] fill_idx;
    logic              fill_done;
    opbyte_t           cur_byte;

    // Entry base register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (base_ld)
            base_q <= base_in;
    end

    opdisp_ptr #(.BUF_BYTES(BUF_BYTES)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ptr_inc),
        .clr   (fill_done),
        .ptr   (ptr)
    );

    opdisp_buf #(.BUF_BYTES(BUF_BYTES), .WORD_W(WORD_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fill_en),
        .wr_idx  (fill_idx),
        .wr_data (mem_rd_data),
        .rd_idx  (ptr[IDX_W-1:0]),
        .rd_byte (cur_byte)
    );

    opdisp_refill #(.WORDS(WORDS)) u_refill (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (refill_start),
        .rd_vld (mem_rd_vld),
        .rd_req (mem_rd_req),
        .busy   (busy),
        .wr_en  (fill_en),
        .wr_idx (fill_idx),
        .done   (fill_done)
    );

    // Same-cycle dispatch resolution: overflow bit picks the refill branch.
    always_comb begin
        ovf       = ptr[IDX_W];
        stall     = disp_req && busy;
        nxt_vld   = disp_req && !busy;
        ptr_inc   = nxt_vld && !ovf;
        nxt_uaddr = ovf ? REFILL_UADDR : {base_q, cur_byte};
    end

    // R7: the pointer is frozen while a refill is pending.
    p_ptr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fill_done) |=> $stable(ptr));

    // R7: the final word leaves the pointer at byte zero.
    p_ptr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (ptr == '0));

    // R7: a stalled dispatch is never reported as resolved.
    p_stall_no_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !nxt_vld);
endmodule

// File: tb/opdisp_unit_test.sv
module opdisp_unit_test;
    localparam int CLK_P = 10;
    localparam logic [11:0] REFILL = 12'h010;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_ld;
    logic [3:0]  base_in;
    logic        disp_req;
    logic        refill_start;
    logic        mem_rd_vld;
    logic [15:0] mem_rd_data;
    logic        nxt_vld;
    logic [11:0] nxt_uaddr;
    logic        stall;
    logic        mem_rd_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] m_buf [8];
    int         m_ptr;
    logic [3:0] m_base;

    opdisp_unit uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_ld      (base_ld),
        .base_in      (base_in),
        .disp_req     (disp_req),
        .refill_start (refill_start),
        .mem_rd_vld   (mem_rd_vld),
        .mem_rd_data  (mem_rd_data),
        .nxt_vld      (nxt_vld),
        .nxt_uaddr    (nxt_uaddr),
        .stall        (stall),
        .mem_rd_req   (mem_rd_req)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_next();
        if (m_ptr >= 8) return REFILL;
        return {m_base, m_buf[m_ptr]};
    endfunction

    // Start a cycle just after the edge with all strobes low.
    task automatic cyc_begin();
        @(posedge clk);
        #1;
        base_ld = 0; disp_req = 0; refill_start = 0; mem_rd_vld = 0;
    endtask

    task automatic mid();
        #(CLK_P/2 - 2);
    endtask

    task automatic dispatch(input string req);
        logic [11:0] e;
        cyc_begin();
        disp_req = 1;
        mid();
        e = exp_next();
        check(nxt_vld == 1'b1, req, "nxt_vld", int'(nxt_vld), 1);
        check(nxt_uaddr == e, req, "nxt_uaddr", int'(nxt_uaddr), int'(e));
        if (m_ptr < 8) m_ptr++;
    endtask

    task automatic idle(input string req);
        cyc_begin();
        mid();
        check(nxt_vld == 1'b0 && stall == 1'b0, req, "idle vld/stall",
              int'({nxt_vld, stall}), 0);
    endtask

    task automatic load_base(input logic [3:0] v, input bit with_disp);
        logic [11:0] e;
        cyc_begin();
        base_ld = 1; base_in = v; disp_req = with_disp;
        mid();
        if (with_disp) begin
            e = exp_next();
            check(nxt_uaddr == e, "R8", "old base same cycle", int'(nxt_uaddr), int'(e));
            if (m_ptr < 8) m_ptr++;
        end
        m_base = v;
    endtask

    task automatic stray_word();
        cyc_begin();
        mem_rd_vld = 1; mem_rd_data = 16'($urandom);
        mid();
        check(nxt_vld == 1'b0, "R9", "stray word no vld", int'(nxt_vld), 0);
    endtask

    // Full refill; hold keeps a dispatch pending from the request cycle on.
    task automatic refill(input bit hold, input bit restart);
        logic [15:0] w;
        int gap;
        cyc_begin();
        refill_start = 1;
        mid();
        check(mem_rd_req == 1'b0, "R5", "no req in start cycle", int'(mem_rd_req), 0);
        cyc_begin();
        disp_req = hold; refill_start = restart;
        mid();
        check(mem_rd_req == 1'b1, "R5", "req pulse", int'(mem_rd_req), 1);
        check(stall == hold, "R7", "stall in req cycle", int'(stall), int'(hold));
        for (int k = 0; k < 4; k++) begin
            gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) begin
                cyc_begin();
                disp_req = hold;
                mid();
                check(mem_rd_req == 1'b0, "R5", "req one cycle only", int'(mem_rd_req), 0);
                check(stall == hold && nxt_vld == 1'b0, "R7", "stall while pending",
                      int'({stall, nxt_vld}), int'({hold, 1'b0}));
            end
            cyc_begin();
            disp_req = hold;
            w = 16'($urandom);
            mem_rd_vld = 1; mem_rd_data = w;
            mid();
            check(stall == hold, "R7", "stall on word", int'(stall), int'(hold));
            m_buf[2*k]   = w[7:0];
            m_buf[2*k+1] = w[15:8];
        end
        m_ptr = 0;
        if (hold) dispatch("R7");
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0D15_A7C4));
        rst_n = 0; base_ld = 0; base_in = 0; disp_req = 0; refill_start = 0;
        mem_rd_vld = 0; mem_rd_data = 0;
        m_ptr = 8; m_base = 0;
        for (int i = 0; i < 8; i++) m_buf[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;

        // R1: reset state and first dispatch to refill entry
        mid();
        check(mem_rd_req == 0 && stall == 0 && nxt_vld == 0, "R1", "reset outputs",
              int'({mem_rd_req, stall, nxt_vld}), 0);
        dispatch("R1");

        // R6, R2, R3: fill then eight back-to-back dispatches
        refill(0, 0);
        load_base(4'hA, 0);
        for (int i = 0; i < 8; i++) dispatch("R3");
        // R4: exhausted, repeated dispatch stays on refill entry
        dispatch("R4");
        dispatch("R4");
        dispatch("R4");

        // R7 and R5: held dispatch during refill with a repeated start
        refill(1, 1);
        // R8: base load with a same-cycle dispatch
        load_base(4'h3, 1);
        dispatch("R8");
        // R10: idle cycles consume nothing
        idle("R10");
        idle("R10");
        dispatch("R10");
        // R9: stray returned word while idle
        stray_word();
        stray_word();
        while (m_ptr < 8) dispatch("R9");
        dispatch("R4");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r <= 5) begin
                if (m_ptr >= 8) begin
                    dispatch("R4");
                    refill(1'($urandom), 1'($urandom));
                end else begin
                    dispatch("R2");
                end
            end else if (r == 6) load_base(4'($urandom), 0);
            else if (r == 7) idle("R10");
            else if (r == 8) stray_word();
            else load_base(4'($urandom), 1);
        end

        cyc_begin();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule